// File: doc/BRIEF.md
# Masked TDM Serial Transmitter

This block sends 16-bit data words onto a serial line divided into a frame of 128 channel slots, one bit per clock. A frame-sync pulse starts a frame at channel 0. Each slot lasts sixteen bit times. A bank of eight 16-bit enable registers selects which slots the block drives. In an enabled slot the block takes one word from a ready/valid input and shifts it out most significant bit first, with the output enable high. In a disabled slot the output enable stays low, so the pad is high-impedance, and the block takes no word.

A host writes and reads the enable registers through a simple register port. The upstream data source sees `wordReady` pulse once for each enabled slot. This lets a packed stream of words be spread over whichever channels are switched on.

Top module: `tdm_mask_tx`

## Requirements
- R1: There are eight enable registers at `regAddr` 0 to 7. Bit n of register k enables channel 16*k + n. A bit value of 1 lets that slot transmit and 0 blocks it.
- R2: A write with `regWrEn` high stores `regWrData` at `regAddr` on the clock edge. `regRdData` always shows the register currently selected by `regAddr`.
- R3: Reset clears every enable bit and holds `txOe` and `wordReady` low.
- R4: A frame-sync sampled high at edge E0 makes channel c occupy edges E0+16c to E0+16c+15. In an enabled slot `txOe` is high for all sixteen bit times, and `txData` after edge E0+16c+b carries bit 15-b of the word.
- R5: `wordReady` is high, for one cycle, only in the cycle whose edge starts an enabled slot. The word present with `wordValid` on that edge is the one shifted out.
- R6: For a disabled slot, `txOe` is low for all sixteen bit times, `wordReady` stays low, and no input word is consumed.
- R7: A frame-sync in the middle of a frame abandons the current slot and restarts at channel 0 on that edge.
- R8: If an enabled slot starts while `wordValid` is low, the slot is still driven (`txOe` high), all its bits are 0, and no word is consumed.
- R9: After the last bit of channel 127, and until the next frame-sync, `txOe` and `wordReady` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one bit per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Enable register select for write and read |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Contents of the selected enable register |
| frameSync | input | 1 | Frame start pulse; channel 0 begins on the edge that samples it |
| wordValid | input | 1 | Source has a word on `wordData` |
| wordData | input | 16 | Word to transmit |
| wordReady | output | 1 | Word taken on this edge (start of an enabled slot) |
| txData | output | 1 | Serial data bit |
| txOe | output | 1 | Pad output enable; low means the line is high-impedance |

## Verification
The bench checks where each slot begins and ends against the register mapping. It uses isolated enabled channels at both ends of the frame (channels 0, 15 and 127). A design with an off-by-one slot count or a swapped partition index would shift data into the wrong slot, or put the output enable in the wrong place.

It also restarts a frame partway through a slot. A design that ignored the mid-frame sync, or kept the old bit count, would misalign every word after the restart. A frame sent with no valid data checks that the slots are still driven with zeros and that no word is consumed. The idle gap after channel 127 must stay undriven. A block that wrapped around to channel 0 on its own would assert `wordReady` there and be counted as an extra transfer.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  // Strobes from slot control to the word datapath
  typedef struct packed {
    logic loadWord;   // start of an enabled slot
    logic blankSlot;  // start of a disabled slot or end of frame
    logic shiftWord;  // advance to next bit inside a slot
  } txStrobe_t;
endpackage

// File: rtl/tdm_en_bank.sv
module tdm_en_bank #(
  parameter int NUM_PART = 8,
  parameter int PART_W   = 16,
  localparam int AW      = $clog2(NUM_PART),
  localparam int NUM_CH  = NUM_PART * PART_W,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     addr,
  input  logic [PART_W-1:0] wrData,
  output logic [PART_W-1:0] rdData,
  input  logic [CH_W-1:0]   chanIdx,
  output logic              chanEn
);
  logic [PART_W-1:0] bank [NUM_PART];
  logic [NUM_CH-1:0] flatEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PART; i++) bank[i] <= '0;
    end else if (wrEn) begin
      bank[addr] <= wrData;
    end
  end

  // channel index = partition * PART_W + bit
  for (genvar p = 0; p < NUM_PART; p++) begin : g_flat
    assign flatEn[p*PART_W +: PART_W] = bank[p];
  end

  assign rdData = bank[addr];
  assign chanEn = flatEn[chanIdx];
endmodule

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int WORD_W = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameSync,
  input  logic            chanEn,
  output logic [CH_W-1:0] nextChan,
  output txStrobe_t       strb
);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [CH_W-1:0]  chanCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             active;
  logic             atLastBit, slotStart, frameEnd;

  assign atLastBit = active && (bitCnt == LAST_BIT);
  assign slotStart = frameSync || (atLastBit && (chanCnt != LAST_CH));
  assign frameEnd  = atLastBit && (chanCnt == LAST_CH) && !frameSync;
  assign nextChan  = frameSync ? '0 : chanCnt + 1'b1;

  always_comb begin
    strb.loadWord  = slotStart && chanEn;
    strb.blankSlot = (slotStart && !chanEn) || frameEnd;
    strb.shiftWord = active && !slotStart && !frameEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanCnt <= '0;
      bitCnt  <= '0;
      active  <= 1'b0;
    end else if (frameSync) begin
      chanCnt <= '0;
      bitCnt  <= '0;
      active  <= 1'b1;
    end else if (active) begin
      if (atLastBit) begin
        bitCnt <= '0;
        if (chanCnt == LAST_CH) active  <= 1'b0;
        else                    chanCnt <= chanCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_dpath.sv
module tdm_tx_dpath
  import tdm_tx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              txData,
  output logic              txOe
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txOe     <= 1'b0;
    end else if (strb.loadWord) begin
      shiftReg <= wordValid ? wordData : '0;
      txOe     <= 1'b1;
    end else if (strb.blankSlot) begin
      shiftReg <= '0;
      txOe     <= 1'b0;
    end else if (strb.shiftWord) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign txData = shiftReg[WORD_W-1];
endmodule

// File: rtl/tdm_mask_tx.sv
module tdm_mask_tx
  import tdm_tx_pkg::*;
#(
  parameter int NUM_PART = 8,
  parameter int PART_W   = 16,
  parameter int WORD_W   = 16,
  localparam int AW      = $clog2(NUM_PART),
  localparam int NUM_CH  = NUM_PART * PART_W,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [AW-1:0]     regAddr,
  input  logic [PART_W-1:0] regWrData,
  output logic [PART_W-1:0] regRdData,
  input  logic              frameSync,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              wordReady,
  output logic              txData,
  output logic              txOe
);
  txStrobe_t       strb;
  logic [CH_W-1:0] nextChan;
  logic            chanEn;

  tdm_en_bank #(.NUM_PART(NUM_PART), .PART_W(PART_W)) u_bank (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData),
    .chanIdx(nextChan), .chanEn(chanEn)
  );

  tdm_tx_ctrl #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .chanEn(chanEn),
    .nextChan(nextChan), .strb(strb)
  );

  tdm_tx_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wordValid(wordValid),
    .wordData(wordData), .txData(txData), .txOe(txOe)
  );

  assign wordReady = strb.loadWord;
endmodule

// File: rtl/tdm_mask_tx_chk.sv
module tdm_mask_tx_chk
  import tdm_tx_pkg::*;
#(
  parameter int AW     = 3,
  parameter int PART_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [AW-1:0]     regAddr,
  input logic [PART_W-1:0] regWrData,
  input logic [PART_W-1:0] regRdData,
  input logic              frameSync,
  input logic              wordReady,
  input logic              txOe,
  input txStrobe_t         strb
);
  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr != $past(regAddr)) || (regRdData == $past(regWrData)));

  p_ready_drives_r5: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |=> txOe);

  p_sync_blank_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !wordReady) |=> !txOe);

  p_oe_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadWord && !strb.blankSlot) |=> $stable(txOe));
endmodule

bind tdm_mask_tx tdm_mask_tx_chk #(.AW(AW), .PART_W(PART_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .frameSync(frameSync),
  .wordReady(wordReady), .txOe(txOe), .strb(strb)
);

// File: tb/tb_tdm_mask_tx.sv
`timescale 1ns/1ps
module tb_tdm_mask_tx;
  localparam int NP = 8, PW = 16, NC = 128, WW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0, regWrEn = 1'b0, frameSync = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [PW-1:0] regWrData = '0, regRdData;
  logic          wordValid, wordReady, txData, txOe;
  logic [WW-1:0] wordData;

  int  total = 0, bad = 0;
  bit  done = 1'b0;
  bit  benchEn [NC];
  bit  qOe [$];
  bit  qBit [$];
  string qTag [$];
  int  ptr = 0, readyCount = 0;
  bit  validOn = 1'b1;

  function automatic logic [WW-1:0] wordFn(int i);
    return WW'(i * 40503 + 15450) ^ 16'h9E37;
  endfunction

  assign wordValid = validOn;
  assign wordData  = wordFn(ptr);

  tdm_mask_tx dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frameSync(frameSync),
    .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
    .txData(txData), .txOe(txOe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // source side: count handshakes, advance word pointer on accepted words
  always @(posedge clk) begin
    if (rstN && wordReady) begin
      readyCount <= readyCount + 1;
      if (wordValid) ptr <= ptr + 1;
    end
  end

  // monitor: pop expected line state, compare
  always @(negedge clk) begin
    if (qOe.size() > 0) begin
      bit eo, eb;
      string tg;
      eo = qOe.pop_front();
      eb = qBit.pop_front();
      tg = qTag.pop_front();
      check({tg, " txOe"}, 32'(txOe), 32'(eo));
      if (eo) check({tg, " txData"}, 32'(txData), 32'(eb));
    end
  end

  task automatic writeReg(int addr, logic [PW-1:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(addr); regWrData = data;
    for (int n = 0; n < PW; n++) benchEn[addr*PW + n] = data[n];  // R1 mapping
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(int addr, logic [PW-1:0] exp, string req);
    @(negedge clk);
    regAddr = 3'(addr);
    #1 check(req, 32'(regRdData), 32'(exp));
  endtask

  // driver: one frame of len cycles (restart or idle tail beyond 2048)
  task automatic runFrame(int len, string tag);
    int p0, r0, k, expReady;
    logic [WW-1:0] w;
    @(negedge clk);
    frameSync = 1'b1;
    p0 = ptr; r0 = readyCount; k = 0; expReady = 0; w = '0;
    @(posedge clk);
    for (int t = 0; t < len; t++) begin
      int c, b;
      c = t / WW; b = t % WW;
      if (c < NC && benchEn[c]) begin
        if (b == 0) begin
          w = validOn ? wordFn(p0 + k) : '0;  // R8 zeros when no word
          if (validOn) k++;
          expReady++;
        end
        qOe.push_back(1'b1); qBit.push_back(w[WW-1-b]); qTag.push_back({tag, " R4"});
      end else begin
        qOe.push_back(1'b0); qBit.push_back(1'b0);
        qTag.push_back(c < NC ? {tag, " R6"} : {tag, " R9"});
      end
    end
    @(negedge clk);
    frameSync = 1'b0;
    if (len > 1) repeat (len - 1) @(posedge clk);
    #1;
    check({tag, " R5 ready count"}, 32'(readyCount - r0), 32'(expReady));
    check({tag, " R6 words consumed"}, 32'(ptr - p0), 32'(k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 txOe in reset", 32'(txOe), 32'd0);
    check("R3 wordReady in reset", 32'(wordReady), 32'd0);
    rstN = 1'b1;
    for (int a = 0; a < NP; a++) readCheck(a, '0, "R3 reg cleared");
    for (int c = 0; c < NC; c++) benchEn[c] = 1'b0;

    runFrame(2048 + 40, "all-off");

    // R1: isolated channels 0,15 (reg0), 52..55/60..63 (reg3), 127 (reg7)
    writeReg(0, 16'h8001);
    writeReg(3, 16'hF0F0);
    writeReg(7, 16'h8000);
    readCheck(0, 16'h8001, "R2 readback reg0");
    readCheck(3, 16'hF0F0, "R2 readback reg3");
    readCheck(7, 16'h8000, "R2 readback reg7");
    readCheck(5, 16'h0000, "R2 readback reg5");
    runFrame(2048 + 40, "sparse");

    validOn = 1'b0;
    runFrame(2048 + 20, "R8 no-data");
    validOn = 1'b1;

    writeReg(0, 16'h00FF);
    readCheck(0, 16'h00FF, "R2 readback reg0 rewrite");
    runFrame(16*5 + 7, "R7 cut");
    runFrame(2048 + 20, "R7 after restart");

    for (int a = 0; a < NP; a++) writeReg(a, 16'hFFFF);
    readCheck(6, 16'hFFFF, "R2 readback reg6");
    runFrame(2048 + 30, "all-on");

    repeat (4) @(negedge clk);
    check("R9 queue drained", 32'(qOe.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule